// File: doc/BRIEF.md
# Chunked Frame Handoff Sequencer

This block pairs two small controllers that pass one raw 4:2:0 video frame from a producing engine to a consuming engine through a shared staging buffer smaller than the largest frame. The producer side writes the frame in pieces. The consumer side copies each piece out. The two sides coordinate only through two single-word symbol queues. The return queue carries symbols from the consumer to the producer. The forward queue carries symbols from the producer to the consumer. Pixel data never passes through the block. It only issues buffer write and read commands with a byte count and a chunk index.

A handoff is a stop-and-wait exchange. First the consumer posts a ready symbol. Then, for each chunk, the producer writes the buffer and posts a chunk announcement. The consumer reads the buffer and returns an acknowledgement. The producer writes the next chunk only after that acknowledgement. The small format (176x144 luma) fits in one chunk. The large format (352x288 luma) needs three chunks. Chunk sizes are derived from the luma size and the buffer size.

Top module: `frame_handoff_seq`

## Requirements
- R1: After reset, every strobe, queue push, queue pop, done, error and stall output is low.
- R2: A start command seen while the object-detected flag is low is ignored. The producer pops nothing from the return queue and writes nothing.
- R3: After an accepted start, the producer issues no buffer write until it pops the ready symbol (code 0) from the return queue.
- R4: Each frame totals 1.5 x luma bytes (38016 small, 152064 large). Chunk k carries min(65536, total - 65536*k) bytes and the chunks go out in index order: one chunk of 38016 for the small format, and 65536, 65536, 20992 for the large one.
- R5: Right after each buffer write, the producer pushes code 1 (more chunks follow) or code 2 (final chunk) onto the forward queue, as soon as that queue is not full.
- R6: The producer holds at most one unacknowledged chunk. It busy-waits, without writing, until it pops the acknowledge symbol (code 3).
- R7: The producer raises its done output for exactly one cycle, in the cycle it pops the final acknowledge. It then returns to idle and accepts a new start.
- R8: While the producer awaits ready, any symbol other than code 0 puts it in a sticky error state. While it awaits an acknowledge, any symbol other than code 3 does the same. In that state it issues no further writes until reset.
- R9: When armed, the consumer pushes code 0 onto the return queue once the queue has room. It then raises its stall output while it waits for an announcement.
- R10: On code 1 or 2, the consumer strobes a buffer read with that chunk's length, then pushes code 3. Its done output pulses for one cycle with the final acknowledge push.
- R11: The consumer enters a sticky error state on code 0 or 3 while it waits for data. It also does so on a code 2 before the last chunk index, or a code 1 at the last chunk index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start_i | input | 1 | Producer start command, one cycle |
| obj_seen_i | input | 1 | Object detected in the frame, qualifies start |
| big_frame_i | input | 1 | Format select: 1 = 352x288, 0 = 176x144 |
| wr_stb_o | output | 1 | Buffer write command |
| wr_len_o | output | 17 | Bytes in the chunk to write |
| wr_idx_o | output | 2 | Index of the chunk to write |
| ret_valid_i | input | 1 | Return queue holds a symbol |
| ret_sym_i | input | 2 | Symbol at the head of the return queue |
| ret_pop_o | output | 1 | Producer pops the return queue |
| fwd_full_i | input | 1 | Forward queue is occupied |
| fwd_push_o | output | 1 | Producer pushes the forward queue |
| fwd_sym_o | output | 2 | Symbol pushed onto the forward queue |
| prod_done_o | output | 1 | Producer frame complete pulse |
| prod_err_o | output | 1 | Producer protocol error |
| cons_arm_i | input | 1 | Consumer arm command, one cycle |
| rd_stb_o | output | 1 | Buffer read command |
| rd_len_o | output | 17 | Bytes in the chunk to read |
| ret_full_i | input | 1 | Return queue is occupied |
| ret_push_o | output | 1 | Consumer pushes the return queue |
| ret_sym_o | output | 2 | Symbol pushed onto the return queue |
| fwd_valid_i | input | 1 | Forward queue holds a symbol |
| fwd_sym_i | input | 2 | Symbol at the head of the forward queue |
| fwd_pop_o | output | 1 | Consumer pops the forward queue |
| cons_stall_o | output | 1 | Consumer is blocked awaiting data |
| cons_done_o | output | 1 | Consumer frame complete pulse |
| cons_err_o | output | 1 | Consumer protocol error |

## Verification
Both formats are swept end to end with the two controllers looped through one-word queue models. The return queue is held blocked for several lengths of time, both before the ready symbol and while the first acknowledge is pending. The early block shows that no write happens before ready. The late block shows that the producer waits and never runs ahead by a chunk. Single-symbol injections into each queue, with the opposite side idle, separate the accepted codes from every illegal code and from mismatches between announcement code and chunk index. A start without the object flag is compared against a start with it.

// File: rtl/fh_pkg.sv
package fh_pkg;
  typedef enum logic [1:0] {
    SYM_RDY   = 2'd0,
    SYM_CHUNK = 2'd1,
    SYM_LAST  = 2'd2,
    SYM_ACK   = 2'd3
  } sym_e;
endpackage

// File: rtl/fh_chunk_table.sv
module fh_chunk_table #(
  parameter int LUMA_QCIF = 25344,
  parameter int LUMA_CIF  = 101376,
  parameter int BUF_BYTES = 65536,
  parameter int LEN_W     = 17,
  parameter int IDX_W     = 2
) (
  input  logic             big_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [LEN_W-1:0] len_o,
  output logic             last_o
);
  localparam logic [31:0] TOT_S = 32'(LUMA_QCIF * 3 / 2);
  localparam logic [31:0] TOT_B = 32'(LUMA_CIF * 3 / 2);
  localparam logic [31:0] BUF32 = 32'(BUF_BYTES);

  logic [31:0] total, base, rem;

  // remaining bytes from this chunk on; a chunk is final when it fits
  always_comb begin
    total  = big_i ? TOT_B : TOT_S;
    base   = 32'(idx_i) * BUF32;
    rem    = total - base;
    last_o = (rem <= BUF32);
    len_o  = last_o ? rem[LEN_W-1:0] : BUF32[LEN_W-1:0];
  end
endmodule

// File: rtl/fh_producer.sv
module fh_producer
  import fh_pkg::*;
#(
  parameter int LUMA_QCIF = 25344,
  parameter int LUMA_CIF  = 101376,
  parameter int BUF_BYTES = 65536,
  parameter int LEN_W     = 17,
  parameter int IDX_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             obj_i,
  input  logic             big_i,
  output logic             wr_stb_o,
  output logic [LEN_W-1:0] wr_len_o,
  output logic [IDX_W-1:0] wr_idx_o,
  input  logic             ret_valid_i,
  input  logic [1:0]       ret_sym_i,
  output logic             ret_pop_o,
  input  logic             fwd_full_i,
  output logic             fwd_push_o,
  output logic [1:0]       fwd_sym_o,
  output logic             done_o,
  output logic             err_o
);
  typedef enum logic [2:0] {P_IDLE, P_WRDY, P_WRITE, P_ANN, P_WACK, P_ERR} pst_e;

  localparam logic [LEN_W-1:0] BUF_L = LEN_W'(BUF_BYTES);

  pst_e             st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en, big_q, big_en;
  logic             last;
  logic [LEN_W-1:0] len;

  fh_chunk_table #(
    .LUMA_QCIF(LUMA_QCIF), .LUMA_CIF(LUMA_CIF), .BUF_BYTES(BUF_BYTES),
    .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_tab (
    .big_i (big_q),
    .idx_i (idx_q),
    .len_o (len),
    .last_o(last)
  );

  assign wr_stb_o   = (st_q == P_WRITE);
  assign wr_len_o   = len;
  assign wr_idx_o   = idx_q;
  assign ret_pop_o  = ((st_q == P_WRDY) || (st_q == P_WACK)) && ret_valid_i;
  assign fwd_push_o = (st_q == P_ANN) && !fwd_full_i;
  assign fwd_sym_o  = last ? SYM_LAST : SYM_CHUNK;
  assign done_o     = (st_q == P_WACK) && ret_valid_i && (ret_sym_i == SYM_ACK) && last;
  assign err_o      = (st_q == P_ERR);

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    idx_en = 1'b0;
    big_en = 1'b0;
    unique case (st_q)
      P_IDLE: if (start_i && obj_i) begin
        st_d   = P_WRDY;
        big_en = 1'b1;
        idx_d  = '0;
        idx_en = 1'b1;
      end
      P_WRDY: if (ret_valid_i) st_d = (ret_sym_i == SYM_RDY) ? P_WRITE : P_ERR;
      P_WRITE: st_d = P_ANN;
      P_ANN:  if (!fwd_full_i) st_d = P_WACK;
      P_WACK: if (ret_valid_i) begin
        if (ret_sym_i != SYM_ACK) st_d = P_ERR;
        else if (last)            st_d = P_IDLE;
        else begin
          st_d   = P_WRITE;
          idx_d  = idx_q + 1'b1;
          idx_en = 1'b1;
        end
      end
      default: st_d = P_ERR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st_q <= P_IDLE;
    else        st_q <= st_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      big_q <= 1'b0;
    else if (big_en) big_q <= big_i;

  // announced-but-unacknowledged chunk count, seen at the queue ports
  logic [1:0] outst_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) outst_q <= 2'd0;
    else if (fwd_push_o) outst_q <= outst_q + 2'd1;
    else if (ret_pop_o && ret_sym_i == SYM_ACK && outst_q != 2'd0) outst_q <= outst_q - 2'd1;

  // R6
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> outst_q == 2'd0);
  // R5
  announce_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o && (fwd_push_o || fwd_full_i));
  // R4
  wr_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> (wr_len_o != '0) && (wr_len_o <= BUF_L));
  // R8
  prod_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o && !wr_stb_o);
endmodule

// File: rtl/fh_consumer.sv
module fh_consumer
  import fh_pkg::*;
#(
  parameter int LUMA_QCIF = 25344,
  parameter int LUMA_CIF  = 101376,
  parameter int BUF_BYTES = 65536,
  parameter int LEN_W     = 17,
  parameter int IDX_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             big_i,
  output logic             rd_stb_o,
  output logic [LEN_W-1:0] rd_len_o,
  input  logic             ret_full_i,
  output logic             ret_push_o,
  output logic [1:0]       ret_sym_o,
  input  logic             fwd_valid_i,
  input  logic [1:0]       fwd_sym_i,
  output logic             fwd_pop_o,
  output logic             stall_o,
  output logic             done_o,
  output logic             err_o
);
  typedef enum logic [2:0] {C_IDLE, C_SRDY, C_WDAT, C_READ, C_SACK, C_ERR} cst_e;

  cst_e             st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en, big_q, big_en;
  logic             last;

  fh_chunk_table #(
    .LUMA_QCIF(LUMA_QCIF), .LUMA_CIF(LUMA_CIF), .BUF_BYTES(BUF_BYTES),
    .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_tab (
    .big_i (big_q),
    .idx_i (idx_q),
    .len_o (rd_len_o),
    .last_o(last)
  );

  assign rd_stb_o   = (st_q == C_READ);
  assign ret_push_o = ((st_q == C_SRDY) || (st_q == C_SACK)) && !ret_full_i;
  assign ret_sym_o  = (st_q == C_SACK) ? SYM_ACK : SYM_RDY;
  assign fwd_pop_o  = (st_q == C_WDAT) && fwd_valid_i;
  assign stall_o    = (st_q == C_WDAT);
  assign done_o     = (st_q == C_SACK) && !ret_full_i && last;
  assign err_o      = (st_q == C_ERR);

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    idx_en = 1'b0;
    big_en = 1'b0;
    unique case (st_q)
      C_IDLE: if (arm_i) begin
        st_d   = C_SRDY;
        big_en = 1'b1;
        idx_d  = '0;
        idx_en = 1'b1;
      end
      C_SRDY: if (!ret_full_i) st_d = C_WDAT;
      C_WDAT: if (fwd_valid_i) begin
        if      (fwd_sym_i == SYM_CHUNK) st_d = last ? C_ERR : C_READ;
        else if (fwd_sym_i == SYM_LAST)  st_d = last ? C_READ : C_ERR;
        else                             st_d = C_ERR;
      end
      C_READ: st_d = C_SACK;
      C_SACK: if (!ret_full_i) begin
        if (last) st_d = C_IDLE;
        else begin
          st_d   = C_WDAT;
          idx_d  = idx_q + 1'b1;
          idx_en = 1'b1;
        end
      end
      default: st_d = C_ERR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st_q <= C_IDLE;
    else        st_q <= st_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      big_q <= 1'b0;
    else if (big_en) big_q <= big_i;

  // port-level trackers for the checks below
  logic rd_pend_q, rdy_sent_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rd_pend_q <= 1'b0;
    else if (rd_stb_o) rd_pend_q <= 1'b1;
    else if (ret_push_o && ret_sym_o == SYM_ACK) rd_pend_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdy_sent_q <= 1'b0;
    else if (ret_push_o && ret_sym_o == SYM_RDY) rdy_sent_q <= 1'b1;
    else if (done_o) rdy_sent_q <= 1'b0;

  // R10
  ack_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_push_o && ret_sym_o == SYM_ACK) |-> rd_pend_q);
  // R9
  ready_before_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_pop_o |-> rdy_sent_q);
  // R11
  cons_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o && !ret_push_o && !rd_stb_o);
endmodule

// File: rtl/frame_handoff_seq.sv
module frame_handoff_seq #(
  parameter int LUMA_QCIF = 25344,
  parameter int LUMA_CIF  = 101376,
  parameter int BUF_BYTES = 65536,
  localparam int LEN_W    = $clog2(BUF_BYTES + 1),
  localparam int MAX_CH   = (LUMA_CIF * 3 / 2 + BUF_BYTES - 1) / BUF_BYTES,
  localparam int IDX_W    = (MAX_CH > 1) ? $clog2(MAX_CH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start_i,
  input  logic             obj_seen_i,
  input  logic             big_frame_i,
  output logic             wr_stb_o,
  output logic [LEN_W-1:0] wr_len_o,
  output logic [IDX_W-1:0] wr_idx_o,
  input  logic             ret_valid_i,
  input  logic [1:0]       ret_sym_i,
  output logic             ret_pop_o,
  input  logic             fwd_full_i,
  output logic             fwd_push_o,
  output logic [1:0]       fwd_sym_o,
  output logic             prod_done_o,
  output logic             prod_err_o,
  input  logic             cons_arm_i,
  output logic             rd_stb_o,
  output logic [LEN_W-1:0] rd_len_o,
  input  logic             ret_full_i,
  output logic             ret_push_o,
  output logic [1:0]       ret_sym_o,
  input  logic             fwd_valid_i,
  input  logic [1:0]       fwd_sym_i,
  output logic             fwd_pop_o,
  output logic             cons_stall_o,
  output logic             cons_done_o,
  output logic             cons_err_o
);
  // reset asserts at once, leaves on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  assign rst_n_int = rst_pipe_q[1];

  fh_producer #(
    .LUMA_QCIF(LUMA_QCIF), .LUMA_CIF(LUMA_CIF), .BUF_BYTES(BUF_BYTES),
    .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_prod (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .start_i    (cmd_start_i),
    .obj_i      (obj_seen_i),
    .big_i      (big_frame_i),
    .wr_stb_o   (wr_stb_o),
    .wr_len_o   (wr_len_o),
    .wr_idx_o   (wr_idx_o),
    .ret_valid_i(ret_valid_i),
    .ret_sym_i  (ret_sym_i),
    .ret_pop_o  (ret_pop_o),
    .fwd_full_i (fwd_full_i),
    .fwd_push_o (fwd_push_o),
    .fwd_sym_o  (fwd_sym_o),
    .done_o     (prod_done_o),
    .err_o      (prod_err_o)
  );

  fh_consumer #(
    .LUMA_QCIF(LUMA_QCIF), .LUMA_CIF(LUMA_CIF), .BUF_BYTES(BUF_BYTES),
    .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_cons (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .arm_i      (cons_arm_i),
    .big_i      (big_frame_i),
    .rd_stb_o   (rd_stb_o),
    .rd_len_o   (rd_len_o),
    .ret_full_i (ret_full_i),
    .ret_push_o (ret_push_o),
    .ret_sym_o  (ret_sym_o),
    .fwd_valid_i(fwd_valid_i),
    .fwd_sym_i  (fwd_sym_i),
    .fwd_pop_o  (fwd_pop_o),
    .stall_o    (cons_stall_o),
    .done_o     (cons_done_o),
    .err_o      (cons_err_o)
  );
endmodule

// File: tb/sim_frame_handoff_seq.sv
module sim_frame_handoff_seq;
  localparam int CLK_P = 10;
  localparam int BUFB  = 65536;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst_n, start, obj, big, arm;
  logic wr_stb, ret_pop, fwd_push, pdone, perr;
  logic rd_stb, ret_push, fwd_pop, stall, cdone, cerr;
  logic [16:0] wr_len, rd_len;
  logic [1:0]  wr_idx, fwd_sym, ret_sym;
  // one-word queue models and bench controls
  logic q1_v, q2_v;
  logic [1:0] q1_s, q2_s;
  logic inj1_v, inj2_v, tbpop1, tbpop2, blk1;
  logic [1:0] inj1_s, inj2_s;

  frame_handoff_seq u0 (
    .clk(clk), .rst_n(rst_n), .cmd_start_i(start), .obj_seen_i(obj), .big_frame_i(big),
    .wr_stb_o(wr_stb), .wr_len_o(wr_len), .wr_idx_o(wr_idx),
    .ret_valid_i(q1_v), .ret_sym_i(q1_s), .ret_pop_o(ret_pop),
    .fwd_full_i(q2_v), .fwd_push_o(fwd_push), .fwd_sym_o(fwd_sym),
    .prod_done_o(pdone), .prod_err_o(perr), .cons_arm_i(arm),
    .rd_stb_o(rd_stb), .rd_len_o(rd_len), .ret_full_i(q1_v | blk1),
    .ret_push_o(ret_push), .ret_sym_o(ret_sym),
    .fwd_valid_i(q2_v), .fwd_sym_i(q2_s), .fwd_pop_o(fwd_pop),
    .cons_stall_o(stall), .cons_done_o(cdone), .cons_err_o(cerr)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin q1_v <= 1'b0; q1_s <= 2'd0; end
    else begin
      if (ret_pop || tbpop1) q1_v <= 1'b0;
      if (ret_push || inj1_v) begin q1_v <= 1'b1; q1_s <= inj1_v ? inj1_s : ret_sym; end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin q2_v <= 1'b0; q2_s <= 2'd0; end
    else begin
      if (fwd_pop || tbpop2) q2_v <= 1'b0;
      if (fwd_push || inj2_v) begin q2_v <= 1'b1; q2_s <= inj2_v ? inj2_s : fwd_sym; end
    end

  int total = 0, bad = 0;
  int nwr, nrd, nfs, nrs, npd, ncd;
  int wl[8], rl[8], fs[8], rs[8];

  // sampled a quarter period after the falling edge
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (rst_n) begin
      if (wr_stb)   begin if (nwr < 8) wl[nwr] = int'(wr_len); nwr++; end
      if (rd_stb)   begin if (nrd < 8) rl[nrd] = int'(rd_len); nrd++; end
      if (fwd_push) begin if (nfs < 8) fs[nfs] = int'(fwd_sym); nfs++; end
      if (ret_push) begin if (nrs < 8) rs[nrs] = int'(ret_sym); nrs++; end
      if (pdone) npd++;
      if (cdone) ncd++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr();
    nwr = 0; nrd = 0; nfs = 0; nrs = 0; npd = 0; ncd = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 0; obj = 0; big = 0; arm = 0;
    inj1_v = 0; inj2_v = 0; inj1_s = 0; inj2_s = 0; tbpop1 = 0; tbpop2 = 0; blk1 = 0;
    cyc(2);
    rst_n = 1'b1;
    cyc(4);
    clr();
  endtask

  task automatic push1(input logic [1:0] s);
    inj1_v = 1; inj1_s = s; cyc(1); inj1_v = 0;
  endtask

  task automatic push2(input logic [1:0] s);
    inj2_v = 1; inj2_s = s; cyc(1); inj2_v = 0;
  endtask

  function automatic int frame_bytes(input bit b);
    return b ? (352 * 288 * 3 / 2) : (176 * 144 * 3 / 2);
  endfunction

  function automatic int exp_len(input bit b, input int k);
    int rem = frame_bytes(b) - k * BUFB;
    return (rem > BUFB) ? BUFB : rem;
  endfunction

  task automatic run_frame(input bit b, input int blk, input int hold);
    int n = (frame_bytes(b) + BUFB - 1) / BUFB;
    int t = 0;
    do_reset();
    big = b; blk1 = (blk > 0); arm = 1; start = 1; obj = 1;
    cyc(1);
    arm = 0; start = 0; obj = 0;
    if (blk > 0) begin
      cyc(blk);
      chk(nwr == 0, "R3 no write before ready", nwr, 0);
      blk1 = 0;
    end
    if (hold > 0) begin
      while (nrd < 1 && t < 3000) begin cyc(1); t++; end
      blk1 = 1;
      cyc(hold);
      chk(nwr == 1, "R6 waits for acknowledge", nwr, 1);
      chk(npd == 0, "R6 no done while ack pending", npd, 0);
      blk1 = 0;
    end
    while ((npd < 1 || ncd < 1) && t < 3000) begin cyc(1); t++; end
    cyc(3);
    chk(nwr == n, "R4 chunk count", nwr, n);
    for (int k = 0; k < n && k < 8; k++) begin
      chk(wl[k] == exp_len(b, k), "R4 write length", wl[k], exp_len(b, k));
      chk(fs[k] == ((k == n - 1) ? 2 : 1), "R5 announce code", fs[k], (k == n - 1) ? 2 : 1);
      chk(rl[k] == exp_len(b, k), "R10 read length", rl[k], exp_len(b, k));
      chk(rs[k + 1] == 3, "R10 acknowledge code", rs[k + 1], 3);
    end
    chk(rs[0] == 0, "R9 ready code first", rs[0], 0);
    chk(nrd == n, "R10 read count", nrd, n);
    chk(npd == 1, "R7 producer done once", npd, 1);
    chk(ncd == 1, "R10 consumer done once", ncd, 1);
    chk(!perr && !cerr, "R8 R11 no error on clean run", int'(perr) + int'(cerr), 0);
    chk(!stall, "R9 stall low when idle", int'(stall), 0);
  endtask

  int cyc_cnt = 0;
  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc_cnt, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clr();
    rst_n = 1'b0;
    do_reset();
    #(CLK_P/4);
    // R1
    chk({wr_stb, rd_stb, ret_pop, fwd_pop, ret_push, fwd_push, pdone, cdone, perr, cerr, stall} == '0,
        "R1 reset outputs", int'(wr_stb) + int'(ret_push) + int'(stall), 0);

    // R2 then R3, R5, R6, R8 on the producer alone
    do_reset();
    push1(2'd0);
    start = 1; obj = 0; cyc(1); start = 0;
    cyc(5);
    chk(q1_v == 1'b1, "R2 ready not popped without object", int'(q1_v), 1);
    chk(nwr == 0, "R2 no write without object", nwr, 0);
    big = 0; start = 1; obj = 1; cyc(1); start = 0; obj = 0;
    cyc(4);
    chk(q1_v == 1'b0, "R3 ready popped", int'(q1_v), 0);
    chk(nwr == 1 && wl[0] == 38016, "R3 R4 small frame write", wl[0], 38016);
    chk(q2_v && q2_s == 2'd2, "R5 final code queued", int'(q2_s), 2);
    cyc(6);
    chk(nwr == 1 && npd == 0, "R6 busy waits", nwr, 1);
    tbpop2 = 1; cyc(1); tbpop2 = 0;
    push1(2'd1);
    cyc(2);
    chk(perr == 1'b1, "R8 bad symbol in ack wait", int'(perr), 1);
    push1(2'd3);
    cyc(4);
    chk(perr == 1'b1 && nwr == 1, "R8 error sticky", nwr, 1);

    do_reset();
    big = 1; start = 1; obj = 1; cyc(1); start = 0; obj = 0;
    push1(2'd3);
    cyc(3);
    chk(perr == 1'b1 && nwr == 0, "R8 bad symbol in ready wait", int'(perr), 1);

    // consumer alone
    do_reset();
    big = 1; arm = 1; cyc(1); arm = 0;
    cyc(3);
    chk(q1_v && q1_s == 2'd0, "R9 ready pushed", int'(q1_s), 0);
    chk(stall == 1'b1, "R9 stall while waiting", int'(stall), 1);
    push2(2'd3);
    cyc(2);
    chk(cerr == 1'b1 && stall == 1'b0 && nrd == 0, "R11 ack code as data", int'(cerr), 1);

    do_reset();
    big = 1; arm = 1; cyc(1); arm = 0;
    cyc(3);
    push2(2'd2);
    cyc(2);
    chk(cerr == 1'b1 && nrd == 0, "R11 final code at first large chunk", int'(cerr), 1);

    do_reset();
    big = 0; arm = 1; cyc(1); arm = 0;
    cyc(3);
    push2(2'd1);
    cyc(2);
    chk(cerr == 1'b1, "R11 more code at last small chunk", int'(cerr), 1);

    do_reset();
    big = 0; arm = 1; cyc(1); arm = 0;
    cyc(3);
    tbpop1 = 1; cyc(1); tbpop1 = 0;
    push2(2'd2);
    cyc(4);
    chk(nrd == 1 && rl[0] == 38016, "R10 read after final code", rl[0], 38016);
    chk(q1_v && q1_s == 2'd3 && ncd == 1, "R10 acknowledge and done", int'(q1_s), 3);

    // looped sweeps over format and queue blocking
    for (int b = 0; b < 2; b++)
      for (int blk = 0; blk < 4; blk++)
        for (int h = 0; h < 2; h++)
          run_frame(b[0], blk * 2, h * 5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule